// File: doc/BRIEF.md
# Write-Posting Banked Memory with Bank Remapping

This block is a banked storage array with two write ports and one read port. Both write ports accept a write in every cycle and never push back. When the two writes in one cycle have different home banks, each goes straight to its home bank. When they share a home bank, port A goes home and port B is diverted into a slot of a small spare bank. A remap table holds a valid flag and a spare slot for each logical address. Reads use this table to find the most recent copy.

In any cycle where the home bank of a diverted entry has no write, a cleanup engine copies that entry from the spare bank back to its home row. In the same cycle it frees the slot and clears the mapping. A logical address is split into a bank index in its low bits and a row index in its high bits. The spare bank has a fixed number of slots. Traffic must not create more live diversions than there are slots.

Top module: `wpm_mem`

## Requirements
- R1: Both write ports are accepted every cycle, with no ready signal. Writes to different home banks (bank = address low log2(NBANK) bits) both reach their home rows in that cycle. Each bank takes at most one write per cycle.
- R2: When both ports write in one cycle to different addresses that share a home bank, port A's write goes home. Port B's write is diverted to the spare bank and its address is mapped. A later read of either address returns the value just written.
- R3: A diverted write to an address that is already mapped reuses that address's existing spare slot. A new spare slot is claimed only when one is free, and the number of mapped addresses never exceeds SPARE.
- R4: When both ports write the same address in one cycle, port B's data is the value kept.
- R5: A write that reaches the home bank of an address that was mapped clears the mapping and frees its slot. Later reads return the new value.
- R6: The cleanup engine moves at most one entry per cycle, and only when that entry's home bank has no port write in that cycle. The mapping is cleared on the same edge as the home write, and reads return the same value before and after the move.
- R7: A read issued in cycle t returns, in cycle t+1 with rd_valid high, the value the address held before the writes of cycle t.
- R8: While reset is asserted, rd_valid stays low even when rd_en is high. After reset the remap table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wa_en | input | 1 | Port A write enable |
| wa_addr | input | AW | Port A logical address |
| wa_data | input | DW | Port A write data |
| wb_en | input | 1 | Port B write enable |
| wb_addr | input | AW | Port B logical address |
| wb_data | input | DW | Port B write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read logical address |
| rd_data | output | DW | Read data, one cycle after the request |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |

## Verification
The bench keeps a reference array and runs long bursts where both ports hit the same bank on every cycle. If a diverted write is lost or landed in the wrong slot, the mismatch shows up when that address is read back. Repeated diversions of one address check slot reuse; a design that claimed a fresh slot each time would overflow the spare bank. Reads issued while cleanup runs check that a read is steered to the spare copy until the move lands, and that a stale spare slot is not used after a home write. Same-address writes on both ports check port B priority. Reads issued alongside writes to the same address check that old data is returned.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  // Which agent owns a home bank's write port in the current cycle
  typedef enum logic [1:0] {
    WS_NONE  = 2'd0,
    WS_PORTA = 2'd1,
    WS_PORTB = 2'd2,
    WS_CLEAN = 2'd3
  } wsrc_e;
endpackage

// File: rtl/wpm_remap.sv
module wpm_remap #(
  parameter int NBANK = 4,
  parameter int ROWS  = 8,
  parameter int SPARE = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               a_go,
  input  logic [$clog2(NBANK*ROWS)-1:0]      a_addr,
  input  logic                               b_home,
  input  logic                               b_div,
  input  logic [$clog2(NBANK*ROWS)-1:0]      b_addr,
  input  logic [NBANK-1:0]                   bank_busy,
  input  logic [$clog2(NBANK*ROWS)-1:0]      rd_addr,
  output logic                               rd_hit,
  output logic [$clog2(SPARE)-1:0]           rd_slot,
  output logic [$clog2(SPARE)-1:0]           div_slot,
  output logic                               cln_go,
  output logic [$clog2(SPARE)-1:0]           cln_slot,
  output logic [$clog2(NBANK*ROWS)-1:0]      cln_addr
);
  localparam int AW    = $clog2(NBANK*ROWS);
  localparam int BW    = $clog2(NBANK);
  localparam int SW    = $clog2(SPARE);
  localparam int NADDR = NBANK*ROWS;

  logic [NADDR-1:0]          vld_q, vld_n;
  logic [NADDR-1:0][SW-1:0]  slot_q, slot_n;
  logic [SPARE-1:0]          used_q, used_n;
  logic [SPARE-1:0][AW-1:0]  own_q, own_n;
  logic                      has_free, alloc;
  logic [SW-1:0]             free_slot;

  // lowest free spare slot
  always_comb begin
    has_free  = 1'b0;
    free_slot = '0;
    for (int i = SPARE-1; i >= 0; i--) begin
      if (!used_q[i]) begin
        has_free  = 1'b1;
        free_slot = SW'(i);
      end
    end
  end

  // lowest occupied slot whose home bank is idle this cycle
  always_comb begin
    cln_go   = 1'b0;
    cln_slot = '0;
    for (int i = SPARE-1; i >= 0; i--) begin
      if (used_q[i] && !bank_busy[own_q[i][BW-1:0]]) begin
        cln_go   = 1'b1;
        cln_slot = SW'(i);
      end
    end
  end

  assign cln_addr = own_q[cln_slot];
  assign alloc    = b_div && !vld_q[b_addr];
  assign div_slot = vld_q[b_addr] ? slot_q[b_addr] : free_slot;
  assign rd_hit   = vld_q[rd_addr];
  assign rd_slot  = slot_q[rd_addr];

  always_comb begin
    vld_n  = vld_q;
    slot_n = slot_q;
    used_n = used_q;
    own_n  = own_q;
    if (a_go && vld_q[a_addr]) begin
      vld_n[a_addr]          = 1'b0;
      used_n[slot_q[a_addr]] = 1'b0;
    end
    if (b_home && vld_q[b_addr]) begin
      vld_n[b_addr]          = 1'b0;
      used_n[slot_q[b_addr]] = 1'b0;
    end
    if (alloc) begin
      vld_n[b_addr]     = 1'b1;
      slot_n[b_addr]    = free_slot;
      used_n[free_slot] = 1'b1;
      own_n[free_slot]  = b_addr;
    end
    if (cln_go) begin
      vld_n[cln_addr]  = 1'b0;
      used_n[cln_slot] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      used_q <= '0;
    end else begin
      vld_q  <= vld_n;
      used_q <= used_n;
    end
  end

  always_ff @(posedge clk) begin
    slot_q <= slot_n;
    own_q  <= own_n;
  end

  // R3: a fresh slot is only claimed while one is free
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> has_free);
  // R3: live mappings never exceed the spare capacity and match slot usage
  a_r3_map_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld_q) <= SPARE) && ($countones(vld_q) == $countones(used_q)));
  // R2: a diverted write leaves its address mapped
  a_r2_div_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    b_div |=> vld_q[$past(b_addr)]);
  // R5: a home write by port A leaves the address unmapped
  a_r5_home_clears: assert property (@(posedge clk) disable iff (!rst_n)
    a_go |=> !vld_q[$past(a_addr)]);
  // R6: the moved entry is unmapped on the edge of its home write
  a_r6_cln_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    cln_go |=> !vld_q[$past(cln_addr)]);
endmodule

// File: rtl/wpm_banks.sv
module wpm_banks #(
  parameter int NBANK = 4,
  parameter int ROWS  = 8,
  parameter int SPARE = 4,
  parameter int DW    = 16
) (
  input  logic                                  clk,
  input  logic [NBANK-1:0]                      hwe,
  input  logic [NBANK-1:0][$clog2(ROWS)-1:0]    hrow,
  input  logic [NBANK-1:0][DW-1:0]              hdat,
  input  logic                                  swe,
  input  logic [$clog2(SPARE)-1:0]              sslot,
  input  logic [DW-1:0]                         sdat,
  input  logic [$clog2(NBANK)-1:0]              rbank,
  input  logic [$clog2(ROWS)-1:0]               rrow,
  input  logic [$clog2(SPARE)-1:0]              rslot,
  input  logic [$clog2(SPARE)-1:0]              cslot,
  output logic [DW-1:0]                         rhome,
  output logic [DW-1:0]                         rspare,
  output logic [DW-1:0]                         cdat
);
  logic [NBANK-1:0][DW-1:0] hrd;
  logic [DW-1:0]            smem [SPARE];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DW-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (hwe[g]) mem[hrow[g]] <= hdat[g];
    end
    assign hrd[g] = mem[rrow];
  end

  always_ff @(posedge clk) begin
    if (swe) smem[sslot] <= sdat;
  end

  assign rhome  = hrd[rbank];
  assign rspare = smem[rslot];
  assign cdat   = smem[cslot];
endmodule

// File: rtl/wpm_mem.sv
module wpm_mem #(
  parameter int NBANK = 4,
  parameter int ROWS  = 8,
  parameter int SPARE = 4,
  parameter int DW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wa_en,
  input  logic [$clog2(NBANK*ROWS)-1:0] wa_addr,
  input  logic [DW-1:0]                 wa_data,
  input  logic                          wb_en,
  input  logic [$clog2(NBANK*ROWS)-1:0] wb_addr,
  input  logic [DW-1:0]                 wb_data,
  input  logic                          rd_en,
  input  logic [$clog2(NBANK*ROWS)-1:0] rd_addr,
  output logic [DW-1:0]                 rd_data,
  output logic                          rd_valid
);
  import wpm_pkg::*;

  localparam int AW = $clog2(NBANK*ROWS);
  localparam int BW = $clog2(NBANK);
  localparam int RW = $clog2(ROWS);
  localparam int SW = $clog2(SPARE);

  logic [BW-1:0] a_bank, b_bank, c_bank;
  logic [RW-1:0] a_row, b_row, c_row;
  logic          a_go, b_home, b_div;
  logic [NBANK-1:0]         bank_busy, hwe;
  logic [NBANK-1:0][RW-1:0] hrow;
  logic [NBANK-1:0][DW-1:0] hdat;
  logic          rd_hit, cln_go;
  logic [SW-1:0] rd_slot, div_slot, cln_slot;
  logic [AW-1:0] cln_addr;
  logic [DW-1:0] rhome, rspare, cdat, rd_word;
  logic          rd_valid_q;
  logic [DW-1:0] rd_data_q;

  assign a_bank = wa_addr[BW-1:0];
  assign a_row  = wa_addr[AW-1:BW];
  assign b_bank = wb_addr[BW-1:0];
  assign b_row  = wb_addr[AW-1:BW];
  assign c_bank = cln_addr[BW-1:0];
  assign c_row  = cln_addr[AW-1:BW];

  // port B wins a same-address pair, so port A is dropped
  assign a_go   = wa_en && !(wb_en && (wb_addr == wa_addr));
  assign b_div  = wb_en && a_go && (b_bank == a_bank);
  assign b_home = wb_en && !b_div;

  for (genvar g = 0; g < NBANK; g++) begin : g_steer
    logic  a_sel, b_sel, c_sel;
    wsrc_e src;
    assign a_sel        = a_go   && (a_bank == BW'(g));
    assign b_sel        = b_home && (b_bank == BW'(g));
    assign c_sel        = cln_go && (c_bank == BW'(g));
    assign bank_busy[g] = a_sel || b_sel;
    assign src = a_sel ? WS_PORTA : b_sel ? WS_PORTB : c_sel ? WS_CLEAN : WS_NONE;
    assign hwe[g] = (src != WS_NONE);
    always_comb begin
      unique case (src)
        WS_PORTA: begin hrow[g] = a_row; hdat[g] = wa_data; end
        WS_PORTB: begin hrow[g] = b_row; hdat[g] = wb_data; end
        WS_CLEAN: begin hrow[g] = c_row; hdat[g] = cdat;    end
        default:  begin hrow[g] = '0;    hdat[g] = '0;      end
      endcase
    end
    // R1: one writer per home bank per cycle
    a_r1_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({a_sel, b_sel, c_sel}) <= 1);
  end

  wpm_remap #(.NBANK(NBANK), .ROWS(ROWS), .SPARE(SPARE)) u_remap (
    .clk(clk), .rst_n(rst_n),
    .a_go(a_go), .a_addr(wa_addr),
    .b_home(b_home), .b_div(b_div), .b_addr(wb_addr),
    .bank_busy(bank_busy), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_slot(rd_slot), .div_slot(div_slot),
    .cln_go(cln_go), .cln_slot(cln_slot), .cln_addr(cln_addr)
  );

  wpm_banks #(.NBANK(NBANK), .ROWS(ROWS), .SPARE(SPARE), .DW(DW)) u_banks (
    .clk(clk), .hwe(hwe), .hrow(hrow), .hdat(hdat),
    .swe(b_div), .sslot(div_slot), .sdat(wb_data),
    .rbank(rd_addr[BW-1:0]), .rrow(rd_addr[AW-1:BW]),
    .rslot(rd_slot), .cslot(cln_slot),
    .rhome(rhome), .rspare(rspare), .cdat(cdat)
  );

  assign rd_word = rd_hit ? rspare : rhome;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data_q <= rd_word;
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: tb/wpm_mem_bench.sv
`timescale 1ns/1ps
module wpm_mem_bench;
  localparam int NBANK = 4;
  localparam int ROWS  = 8;
  localparam int SPARE = 4;
  localparam int DW    = 16;
  localparam int AW    = 5;
  localparam int NADDR = NBANK*ROWS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wa_en, wb_en, rd_en;
  logic [AW-1:0] wa_addr, wb_addr, rd_addr;
  logic [DW-1:0] wa_data, wb_data, rd_data;
  logic          rd_valid;

  int ref_mem [NADDR];
  int checks = 0;
  int errors = 0;
  int coll   = 0;

  always #2 clk = ~clk;

  wpm_mem #(.NBANK(NBANK), .ROWS(ROWS), .SPARE(SPARE), .DW(DW)) u_wpm_mem (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check one edge later
  task automatic tick(bit ae, int aa, int ad, bit be, int ba, int bd,
                      bit re, int ra, string tag);
    int exp;
    wa_en = ae; wa_addr = AW'(aa); wa_data = DW'(ad);
    wb_en = be; wb_addr = AW'(ba); wb_data = DW'(bd);
    rd_en = re; rd_addr = AW'(ra);
    exp = ref_mem[ra];
    if (ae) ref_mem[aa] = ad & 16'hFFFF;
    if (be) ref_mem[ba] = bd & 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    chk(rd_valid == re, {tag, " R7 valid"}, int'(rd_valid), int'(re));
    if (re) chk(rd_data == DW'(exp), tag, int'(rd_data), exp);
  endtask

  // stimulus budget: never more same-bank collisions than spare slots before idling
  task automatic cyc(bit ae, int aa, int ad, bit be, int ba, int bd,
                     bit re, int ra, string tag);
    if (ae && be && (aa % NBANK) == (ba % NBANK) && aa != ba) begin
      if (coll >= SPARE) begin
        for (int k = 0; k < SPARE; k++) tick(0, 0, 0, 0, 0, 0, 1, k, "R6 drain");
        coll = 0;
      end
      coll++;
    end
    tick(ae, aa, ad, be, ba, bd, re, ra, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wa_en = 0; wb_en = 0; wa_addr = '0; wb_addr = '0; wa_data = '0; wb_data = '0;
    rd_en = 1'b1; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R8 reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    rd_en = 1'b0;

    // R1: fill every address, pairs in different banks
    for (int i = 0; i < NADDR/2; i++)
      cyc(1, 2*i, 16'h1000 + i, 1, 2*i+1, 16'h2000 + i, 0, 0, "R1 fill");
    for (int i = 0; i < NADDR; i++)
      cyc(0, 0, 0, 0, 0, 0, 1, i, "R1 readback");

    // R2 / R7: same-bank collision, read old then new while bank stays busy
    cyc(1, 0, 16'hA0A0, 1, 4, 16'hB4B4, 1, 4, "R7 read-before-write");
    cyc(1, 8, 16'hA8A8, 0, 0, 0, 1, 4, "R2 diverted read");
    cyc(1, 12, 16'h0C0C, 0, 0, 0, 1, 0, "R2 home read");

    // R3: repeated diversion of one address reuses its slot
    for (int j = 0; j < 6; j++)
      cyc(1, 16 + 4*(j % 2), 16'h3300 + j, 1, 4, 16'h4400 + j, 1, 4, "R3 reuse");
    cyc(1, 28, 16'h5555, 0, 0, 0, 1, 4, "R3 latest");

    // R4: same address on both ports
    cyc(1, 9, 16'hAAAA, 1, 9, 16'hBBBB, 0, 0, "R4 write");
    cyc(0, 0, 0, 0, 0, 0, 1, 9, "R4 port B wins");

    // R5: home write of a mapped address by port A
    cyc(1, 1, 16'h1111, 1, 5, 16'h5151, 0, 0, "R5 divert");
    cyc(1, 5, 16'h5EED, 0, 0, 0, 1, 5, "R5 before");
    cyc(0, 0, 0, 0, 0, 0, 1, 5, "R5 after home write");
    cyc(1, 13, 16'hD1D1, 1, 5, 16'h5A5A, 0, 0, "R5 divert again");
    cyc(0, 0, 0, 1, 5, 16'h5B5B, 1, 5, "R5 port B home");
    cyc(0, 0, 0, 0, 0, 0, 1, 5, "R5 port B home read");

    // R6: several diversions, then reads while cleanup moves them
    cyc(1, 2, 16'h0202, 1, 6, 16'h0606, 0, 0, "R6 load");
    cyc(1, 3, 16'h0303, 1, 7, 16'h0707, 0, 0, "R6 load");
    cyc(1, 10, 16'h0A0A, 1, 14, 16'h0E0E, 1, 6, "R6 load");
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, 6, "R6 during cleanup");
      cyc(0, 0, 0, 0, 0, 0, 1, 7, "R6 during cleanup");
      cyc(0, 0, 0, 0, 0, 0, 1, 14, "R6 during cleanup");
    end

    // adversarial same-bank bursts on both ports
    for (int k = 0; k < 24; k++) begin
      for (int j = 0; j < 2*SPARE; j++) begin
        int bk = k % NBANK;
        int ra = ((j + 1) % ROWS) * NBANK + bk;
        cyc(1, (j % ROWS) * NBANK + bk, int'($urandom) & 16'hFFFF,
            1, ra, int'($urandom) & 16'hFFFF, 1,
            int'($urandom % ROWS) * NBANK + bk, "R2 burst");
      end
    end

    // random traffic
    for (int n = 0; n < 4000; n++)
      cyc(bit'($urandom % 2), int'($urandom % NADDR), int'($urandom) & 16'hFFFF,
          bit'($urandom % 2), int'($urandom % NADDR), int'($urandom) & 16'hFFFF,
          bit'($urandom % 2), int'($urandom % NADDR), "R1 random");

    for (int i = 0; i < NADDR; i++)
      cyc(0, 0, 0, 0, 0, 0, 1, i, "R6 final sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule